// File: doc/BRIEF.md
# SD Command Path Engine

This block runs the command half of an SD host. Software loads an argument, a response timeout and a command word through a small register port. Writing the command word with its start flag set launches one transaction. The engine drives a 48-bit command frame, protected by CRC7, onto the CMD line, one bit per clock. It then listens for a short (48-bit) response, a long (136-bit) response or none, bounded by a countdown timer. If requested, it also waits for the card to leave its busy period.

The start flag stays set while the transaction runs, so software polls it to learn when the command is finished. A failure raises a fail flag in the command word and records its cause in a sticky status register, which is cleared by writing ones. A received response is placed in four 32-bit words. Data lines, bus clock generation and card power are handled elsewhere. The line rate equals the `clk` rate.

Register offsets on `reg_addr`: 0 command word, 1 argument, 2 timeout start value, 3 status, 4 to 7 response words 0 to 3.

Top module: `sd_cmd_engine`

## Requirements
- R1: Command word bits are: index 5:0, read-data 6, write-data 7, long response 9, no response 10, busy wait 11, fail 14, new 15. A write to offset 0 with bit 15 set starts a command. Bit 15 reads as 1 from the cycle after that write until the command ends, then reads 0. Bits 13:0 read back as written.
- R2: While the frame is sent, `cmd_oe` is 1 for exactly 48 cycles, starting the cycle after the start write. `cmd_out` carries the frame MSB first: start 0, transmission 1, index, argument, CRC7 over the preceding 40 bits (x^7+x^3+1), then stop 1. For index 0 with argument 0, the last byte is 0x95. At all other times `cmd_oe` is 0 and `cmd_out` is 1.
- R3: With bit 10 set, bit 15 clears on the edge that ends the frame, and no response is awaited.
- R4: The timeout register resets to 1024. After the frame, the engine samples `cmd_in` at most T+1 times, where T is the timeout value. A 0 seen in any of these samples begins the response. If none is seen, bit 15 clears, bit 14 sets, and status bit 6 (command timeout) sets.
- R5: For a short response, word 0 receives frame bits 39:8 and words 1 to 3 become 0. If the CRC7 of frame bits 47:8 differs from bits 7:1, bit 14 and status bit 4 set.
- R6: For a long response, words 0 to 3 receive frame bits 31:0, 63:32, 95:64 and 127:96. The CRC check covers only bits 127:8, so the leading 8 bits cannot cause a CRC error.
- R7: With bit 11 set, after a good response (or after the frame, if bit 10 is set) the engine waits for `card_busy` to be low. It then sets status bit 10 and clears bit 15. If `card_busy` stays high past the timeout, bit 14 and status bit 6 set instead.
- R8: A start write with both bit 9 and bit 11 set is refused. Bit 14 reads 1, bit 15 reads 0, and no frame is sent.
- R9: A write to offset 0 while bit 15 is set is ignored entirely.
- R10: Writing 1 to status bits 10:3 clears them. A newly accepted command clears bit 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CMD bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of register at reg_addr (combinational) |
| cmd_out | output | 1 | CMD line drive value |
| cmd_oe | output | 1 | CMD line drive enable |
| cmd_in | input | 1 | CMD line sampled value |
| card_busy | input | 1 | High while the card signals busy |

## Verification
The bench goes after the exact edge of the response window. A start bit on the last allowed sample must be accepted, and one sample later must time out; an off-by-one counter would misreport one of these two cases. It flips a bit inside the leading 8 bits of a long response, which a CRC window that is too wide would flag. It also flips bits in the CRC field and in the body, which a missing check would pass silently. It issues a refused long-plus-busy command and a command written over a running one. An engine that starts either of these would show a second frame on `cmd_oe`. Finally, it holds `card_busy` past the response to show that completion waits for the busy period to end.

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter logic [31:0] TOUT_RST = 32'd1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_out,
  output logic        cmd_oe,
  input  logic        cmd_in,
  input  logic        card_busy
);
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam logic [7:0] SHORT_TOP = 8'(FRAME_BITS - 2);
  localparam logic [7:0] LONG_TOP  = 8'(LONG_BITS - 2);
  localparam logic [7:0] LONG_CRC_TOP = 8'd127;
  localparam logic [10:0] CLR_MASK = 11'h7F8;

  typedef enum logic [2:0] {S_IDLE, S_TX, S_WAIT, S_RX, S_BUSY} st_t;

  st_t          st;
  logic [15:0]  cmd_q;
  logic [31:0]  arg_q, tout_q, tcnt;
  logic [10:0]  sts_q;
  logic [127:0] resp_q;
  logic [47:0]  tx_sh;
  logic [126:0] rx_sh;
  logic [7:0]   bcnt;
  logic [6:0]   crc_q;

  function automatic logic [6:0] crc_step(input logic [6:0] c, input logic b);
    logic fb;
    fb = c[6] ^ b;
    return {c[5:3], c[2] ^ fb, c[1:0], fb};
  endfunction

  function automatic logic [6:0] crc40(input logic [39:0] d);
    logic [6:0] c;
    c = '0;
    for (int i = 39; i >= 0; i--) c = crc_step(c, d[i]);
    return c;
  endfunction

  wire cmd_wr    = reg_wr && (reg_addr == 3'd0);
  wire start_req = cmd_wr && !cmd_q[15] && reg_wdata[15];
  wire refuse    = reg_wdata[9] && reg_wdata[11];
  wire [39:0] fr40 = {2'b01, reg_wdata[5:0], arg_q};
  wire [127:0] rx_full = {rx_sh, cmd_in};
  wire crc_win = (bcnt >= 8'd8) && (bcnt <= (cmd_q[9] ? LONG_CRC_TOP : SHORT_TOP));

  assign cmd_oe  = (st == S_TX);
  assign cmd_out = cmd_oe ? tx_sh[47] : 1'b1;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {16'b0, cmd_q};
      3'd1:    reg_rdata = arg_q;
      3'd2:    reg_rdata = tout_q;
      3'd3:    reg_rdata = {21'b0, sts_q};
      3'd4:    reg_rdata = resp_q[31:0];
      3'd5:    reg_rdata = resp_q[63:32];
      3'd6:    reg_rdata = resp_q[95:64];
      default: reg_rdata = resp_q[127:96];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cmd_q  <= '0;
      arg_q  <= '0;
      tout_q <= TOUT_RST;
      tcnt   <= '0;
      sts_q  <= '0;
      resp_q <= '0;
      tx_sh  <= '1;
      rx_sh  <= '0;
      bcnt   <= '0;
      crc_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == 3'd1) arg_q  <= reg_wdata;
      if (reg_wr && reg_addr == 3'd2) tout_q <= reg_wdata;
      if (reg_wr && reg_addr == 3'd3) sts_q  <= sts_q & ~(reg_wdata[10:0] & CLR_MASK);
      if (cmd_wr && !cmd_q[15]) begin
        if (!reg_wdata[15])  cmd_q[13:0] <= reg_wdata[13:0];
        else if (refuse)     cmd_q <= {2'b01, reg_wdata[13:0]};
        else                 cmd_q <= {2'b10, reg_wdata[13:0]};
      end

      case (st)
        S_IDLE: if (start_req && !refuse) begin
          st    <= S_TX;
          tx_sh <= {fr40, crc40(fr40), 1'b1};
          bcnt  <= 8'(FRAME_BITS - 1);
        end
        S_TX: begin
          tx_sh <= {tx_sh[46:0], 1'b1};
          if (bcnt == 8'd0) begin
            tcnt <= tout_q;
            if (!cmd_q[10])      st <= S_WAIT;
            else if (cmd_q[11])  st <= S_BUSY;
            else begin
              st        <= S_IDLE;
              cmd_q[15] <= 1'b0;
            end
          end else bcnt <= bcnt - 8'd1;
        end
        S_WAIT: begin
          if (!cmd_in) begin
            st    <= S_RX;
            bcnt  <= cmd_q[9] ? LONG_TOP : SHORT_TOP;
            crc_q <= '0;
          end else if (tcnt == 32'd0) begin
            st        <= S_IDLE;
            cmd_q[15] <= 1'b0;
            cmd_q[14] <= 1'b1;
            sts_q[6]  <= 1'b1;
          end else tcnt <= tcnt - 32'd1;
        end
        S_RX: begin
          rx_sh <= rx_full[126:0];
          if (crc_win) crc_q <= crc_step(crc_q, cmd_in);
          if (bcnt == 8'd0) begin
            resp_q <= cmd_q[9] ? rx_full : {96'b0, rx_full[39:8]};
            tcnt   <= tout_q;
            if (crc_q != rx_sh[6:0]) begin
              st        <= S_IDLE;
              cmd_q[15] <= 1'b0;
              cmd_q[14] <= 1'b1;
              sts_q[4]  <= 1'b1;
            end else if (cmd_q[11]) st <= S_BUSY;
            else begin
              st        <= S_IDLE;
              cmd_q[15] <= 1'b0;
            end
          end else bcnt <= bcnt - 8'd1;
        end
        S_BUSY: begin
          if (!card_busy) begin
            st        <= S_IDLE;
            cmd_q[15] <= 1'b0;
            sts_q[10] <= 1'b1;
          end else if (tcnt == 32'd0) begin
            st        <= S_IDLE;
            cmd_q[15] <= 1'b0;
            cmd_q[14] <= 1'b1;
            sts_q[6]  <= 1'b1;
          end else tcnt <= tcnt - 32'd1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_drive_only_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_q[15]);
  assert_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_q[15]) |=> (cmd_q[13:0] == $past(cmd_q[13:0])));
  assert_no_long_busy_sent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> !(cmd_q[9] && cmd_q[11]));
  assert_crc_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[4]) |-> (cmd_q[14] && !cmd_q[15]));
  assert_timeout_fail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[6]) |-> (cmd_q[14] && !cmd_q[15]));
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[10]) |-> (cmd_q[11] && !cmd_q[15] && !card_busy));
endmodule

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;
  localparam int CLK_P = 10;
  localparam int T = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_out, cmd_oe;
  logic cmd_in = 1'b1, card_busy = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  sd_cmd_engine dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_out(cmd_out), .cmd_oe(cmd_oe),
    .cmd_in(cmd_in), .card_busy(card_busy));

  function automatic logic [6:0] ref_crc(input logic [135:0] v, input int hi, input int lo);
    logic [6:0] c = '0;
    for (int i = hi; i >= lo; i--) begin
      logic fb = c[6] ^ v[i];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  // issue a command and compare the line against the model on every clock of the frame
  task automatic send(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] flags,
                      output logic [47:0] cap);
    logic [39:0] f40;
    logic [47:0] exp;
    logic [31:0] w;
    logic [15:0] word;
    bit oe_ok = 1;
    f40  = {2'b01, idx, arg};
    exp  = {f40, ref_crc({96'b0, f40}, 39, 0), 1'b1};
    word = 16'h8000 | (flags & 16'h3FC0) | {10'b0, idx};
    wr(3'd1, arg);
    wr(3'd0, {16'b0, word});
    rd(3'd0, w);
    chk(w[15:0] == {2'b10, word[13:0]}, "R1 R10 word readback", w, {2'b10, word[13:0]});
    for (int k = 0; k < 48; k++) begin
      cap[47-k] = cmd_out;
      if (!cmd_oe) oe_ok = 0;
      if (k < 47) @(negedge clk);
    end
    chk(oe_ok && cap == exp, "R2 frame", cap, exp);
  endtask

  task automatic respond(input int d, input logic [135:0] fr, input int total);
    repeat (1 + d) @(negedge clk);
    for (int j = total - 1; j >= 0; j--) begin
      cmd_in = fr[j];
      @(negedge clk);
    end
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle(input int lim);
    logic [31:0] w;
    for (int i = 0; i < lim; i++) begin
      rd(3'd0, w);
      if (!w[15]) break;
      @(negedge clk);
    end
  endtask

  task automatic count_oe(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (cmd_oe) c++;
    end
  endtask

  function automatic logic [135:0] short_fr(input logic [5:0] idx, input logic [31:0] d);
    logic [39:0] f = {2'b00, idx, d};
    return {88'b0, f, ref_crc({96'b0, f}, 39, 0), 1'b1};
  endfunction

  function automatic logic [135:0] long_fr(input logic [119:0] body);
    logic [135:0] v = {8'h3F, body, 8'h00};
    return {8'h3F, body, ref_crc(v, 127, 8), 1'b1};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [47:0] cap;
    logic [31:0] w, w1, w2, w3;
    logic [135:0] fr;
    int c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, w); chk(w == 0, "R1 reset word", w, 0);
    rd(3'd3, w); chk(w == 0, "R10 reset status", w, 0);
    rd(3'd2, w); chk(w == 32'd1024, "R4 reset timeout", w, 1024);
    chk(!cmd_oe && cmd_out, "R2 idle line", {cmd_oe, cmd_out}, 2'b01);
    wr(3'd2, T);

    // R3 and CMD0 constant
    send(6'd0, 32'd0, 16'h0400, cap);
    chk(cap[7:0] == 8'h95, "R2 cmd0 tail byte", cap[7:0], 8'h95);
    rd(3'd0, w); chk(w[15], "R3 busy in last bit", w, 32'h8000);
    @(negedge clk);
    rd(3'd0, w); chk(!w[15] && !cmd_oe, "R3 done after frame", {cmd_oe, w}, 0);

    // R5 short good, response on the last allowed sample (R4)
    send(6'd17, 32'hDEADBEEF, 16'h0040, cap);
    respond(T, short_fr(6'd17, 32'h12345678), 48);
    rd(3'd0, w); chk(!w[15] && !w[14], "R4 start at last sample accepted", w, 0);
    rd(3'd3, w); chk(w == 0, "R5 no error", w, 0);
    rd(3'd4, w); rd(3'd5, w1); rd(3'd6, w2); rd(3'd7, w3);
    chk({w3, w2, w1, w} == {96'b0, 32'h12345678}, "R5 short words", {w3, w2, w1, w}, {96'b0, 32'h12345678});

    // R5 bad CRC field
    send(6'd13, 32'h0000_0001, 16'h0000, cap);
    fr = short_fr(6'd13, 32'hCAFEF00D) ^ 136'h8;
    respond(2, fr, 48);
    rd(3'd0, w); chk(w[14] && !w[15], "R5 crc fail flag", w, 32'h4000);
    rd(3'd3, w); chk(w == 32'h10, "R5 crc cause", w, 32'h10);
    wr(3'd3, 32'h7F8);
    rd(3'd3, w); chk(w == 0, "R10 w1c", w, 0);

    // R6 long good
    send(6'd2, 32'h0, 16'h0200, cap);
    fr = long_fr(120'hA1B2C3D4_E5F60718_293A4B5C_6D7E8F);
    respond(0, fr, 136);
    rd(3'd3, w); chk(w == 0, "R6 long no error", w, 0);
    rd(3'd4, w); rd(3'd5, w1); rd(3'd6, w2); rd(3'd7, w3);
    chk({w3, w2, w1, w} == fr[127:0], "R6 long words", {w3, w2, w1, w}, fr[127:0]);

    // R6 header bit ignored by CRC
    send(6'd9, 32'h5, 16'h0200, cap);
    fr = long_fr(120'h0F0F0F0F_12121212_34343434_565656) ^ (136'h1 << 130);
    respond(1, fr, 136);
    rd(3'd3, w); chk(w == 0, "R6 header outside crc", w, 0);

    // R6 body bit caught
    send(6'd9, 32'h5, 16'h0200, cap);
    fr = long_fr(120'h0F0F0F0F_12121212_34343434_565656) ^ (136'h1 << 60);
    respond(1, fr, 136);
    rd(3'd3, w); chk(w == 32'h10, "R6 body crc error", w, 32'h10);
    rd(3'd4, w); rd(3'd5, w1); rd(3'd6, w2); rd(3'd7, w3);
    chk({w3, w2, w1, w} == fr[127:0], "R6 words kept on error", {w3, w2, w1, w}, fr[127:0]);
    wr(3'd3, 32'h7F8);

    // R4 exact timeout
    send(6'd8, 32'h1AA, 16'h0000, cap);
    repeat (1 + T) @(negedge clk);
    rd(3'd0, w); chk(w[15], "R4 still waiting", w, 32'h8000);
    @(negedge clk);
    rd(3'd0, w); chk(!w[15] && w[14], "R4 timeout flags", w, 32'h4000);
    rd(3'd3, w); chk(w == 32'h40, "R4 timeout cause", w, 32'h40);
    wr(3'd3, 32'h7F8);

    // R7 busy after short response
    card_busy = 1'b1;
    send(6'd7, 32'h1, 16'h0800, cap);
    respond(0, short_fr(6'd7, 32'h900), 48);
    rd(3'd0, w); rd(3'd3, w1);
    chk(w[15] && w1 == 0, "R7 waits on busy", {w1, w}, 32'h8000);
    repeat (5) @(negedge clk);
    card_busy = 1'b0;
    @(negedge clk);
    rd(3'd0, w); rd(3'd3, w1);
    chk(!w[15] && !w[14] && w1 == 32'h400, "R7 busy end event", {w1, w}, {32'h400, 32'h0807});
    wr(3'd3, 32'h400);
    rd(3'd3, w); chk(w == 0, "R10 busy bit w1c", w, 0);

    // R7 busy timeout, no response
    card_busy = 1'b1;
    send(6'd12, 32'h0, 16'h0C00, cap);
    wait_idle(200);
    card_busy = 1'b0;
    rd(3'd0, w); rd(3'd3, w1);
    chk(w[14] && !w[15] && w1 == 32'h40, "R7 busy timeout", {w1, w}, {32'h40, 32'h4000});
    wr(3'd3, 32'h7F8);

    // R8 refused combination
    wr(3'd0, 32'h8A02);
    rd(3'd0, w); chk(w == 32'h4A02, "R8 refused word", w, 32'h4A02);
    count_oe(60, c); chk(c == 0, "R8 nothing sent", c, 0);

    // R9 write during a live command
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h8405);
    wr(3'd0, 32'h8009);
    rd(3'd0, w); chk(w == 32'h8405, "R9 overwrite ignored", w, 32'h8405);
    wait_idle(200);
    count_oe(60, c); chk(c == 0, "R9 no second frame", c, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule